// File: doc/BRIEF.md
# JTAG Port Sequencer

This block drives a four-wire JTAG port plus its test reset from a small command set. A controller hands it one command at a time over a valid/ready handshake. The commands are:

- reset the port;
- release the test reset;
- open an instruction-register shift or a data-register shift;
- close an open shift;
- idle for a number of clock pulses;
- shift up to 32 bits, with or without driving TDI.

The block turns each command into a short run of TCK pulses. The TMS level for each pulse is taken least-significant bit first from a fixed word. Sampled TDO bits come back as a response word, least-significant bit first.

The block does not mirror the full 16-state TAP controller. It keeps a coarse port state: reset, committed, run or data. Data means a shift is open. A close command is only clocked out when a shift is open. The idle command and both shift-open commands close any open shift first.

Each TCK pulse is built from three equal waits of `HALF` system clocks: a low lead-in, a high phase and a low tail. TMS is changed only before the lead-in of a pulse. TDI is changed only after the tail of a pulse.

Top module: `jtag_seq`

## Requirements
- R1: After rst_n is released, tck=0, tms=1, tdi=1, trst_n=0, cmd_ready=1 and port_state=0. The port_state codes are 0 reset, 1 committed, 2 run and 3 data.
- R2: Op 0 (port reset) behaves as follows:
  - it drives trst_n low and tdi high;
  - it clocks 7 pulses with TMS levels 1,1,1,1,1,0,0;
  - it sets port_state to 0.
- R3: Op 1 (release) sets trst_n high, clocks no pulse and leaves port_state unchanged.
- R4: Op 4 (commit) depends on port_state:
  - at 3, it clocks two pulses with TMS 1,1 and sets port_state to 1;
  - in any other state, it clocks nothing and leaves port_state unchanged.
- R5: Op 5 (run idle) performs the conditional commit of R4, then clocks cmd_len pulses with TMS 0, then sets port_state to 2.
- R6: Op 2 (IR shift) performs the conditional commit, then clocks TMS 1,1,0. Op 3 (DR shift) performs the conditional commit, then clocks TMS 1,0. Both set port_state to 3.
- R7: Op 6 (shift out) clocks cmd_len[4:0]+1 pulses and works bit by bit:
  - after pulse b it drives tdi with bit b of cmd_data, then samples tdo into rsp_data bit b;
  - the first pulse therefore carries the previous tdi level.
- R8: Op 7 (shift in) clocks cmd_len[4:0]+1 pulses and samples tdo into rsp_data bit by bit. It leaves tdi unchanged. Neither shift op changes tms or port_state.
- R9: Every TCK pulse has its high phase lasting exactly HALF clocks. TMS and TDI are stable while tck is high.
- R10: A command is accepted when cmd_valid and cmd_ready are both high. cmd_ready stays low until rsp_done has pulsed for exactly one clock. port_state changes only on the clock after rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_len | input | RUN_W | Idle pulse count, or shift length minus one in the low 5 bits |
| cmd_data | input | DW | Bits to drive on TDI for a shift out |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | DW | Sampled TDO bits, LSB first |
| port_state | output | 2 | Coarse tracked port state |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| trst_n | output | 1 | Test reset, active low |
| tdo | input | 1 | Test data from target |

## Verification
The sequencer is driven with each TMS word on its own and with combinations:
- The reset pattern of five ones and two zeros.
- Both shift-open words, from a non-data state and from an open shift. The second case separates a missing pre-commit from a spurious one.
- A close from an idle state, which must clock nothing, and a close from an open shift, which must clock two ones.

Shift traffic uses distinct bit patterns:
- a byte shifted out against a different byte coming back, which exposes the one-pulse lag of TDI behind the pulses;
- a full 32-bit shift in, which shows that TDI is left alone and that capture order is correct;
- a one-bit shift, which tests the length boundary.

Pulse high widths are measured on every command.

// File: rtl/jtag_seq.sv
module jtag_seq #(
  parameter int HALF  = 4,
  parameter int RUN_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [RUN_W-1:0] cmd_len,
  input  logic [DW-1:0]    cmd_data,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_data,
  output logic [1:0]       port_state,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             trst_n,
  input  logic             tdo
);
  localparam int SHW = $clog2(DW);
  localparam int LW  = (RUN_W > SHW) ? RUN_W + 1 : SHW + 1;
  localparam int CW  = $clog2(HALF + 1);

  localparam logic [2:0] OP_RST = 3'd0, OP_REL = 3'd1, OP_IR  = 3'd2, OP_DR  = 3'd3,
                         OP_CMT = 3'd4, OP_RUN = 3'd5, OP_SHO = 3'd6, OP_SHI = 3'd7;
  localparam logic [1:0] ST_RST = 2'd0, ST_CMT = 2'd1, ST_RUN = 2'd2, ST_DAT = 2'd3;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_SET, PH_PRE, PH_HIGH, PH_LOW, PH_DONE} ph_t;

  ph_t              ph;
  logic [CW-1:0]    pcnt;
  logic [DW-1:0]    word, cap, data_q;
  logic [LW-1:0]    left;
  logic [SHW-1:0]   idx;
  logic [2:0]       op_q;
  logic [RUN_W-1:0] len_q;
  logic             drv_tms, drv_tdi, smp, pend;

  logic [DW-1:0] m_word;
  logic [LW-1:0] m_left;
  logic          m_tms, m_tdi, m_smp, need_pc, wait_end;
  logic [1:0]    st_nxt;

  assign cmd_ready = (ph == PH_IDLE);
  assign rsp_done  = (ph == PH_DONE);
  assign rsp_data  = cap;
  assign wait_end  = (pcnt == CW'(HALF - 1));
  assign need_pc   = (port_state == ST_DAT) &&
                     (op_q == OP_IR || op_q == OP_DR || op_q == OP_RUN || op_q == OP_CMT);

  always_comb begin
    m_word = '0;
    m_left = '0;
    m_tms  = 1'b0;
    m_tdi  = 1'b0;
    m_smp  = 1'b0;
    case (op_q)
      OP_RST: begin m_word = DW'(7'h1F); m_left = LW'(7); m_tms = 1'b1; end
      OP_IR:  begin m_word = DW'(3'b011); m_left = LW'(3); m_tms = 1'b1; end
      OP_DR:  begin m_word = DW'(2'b01); m_left = LW'(2); m_tms = 1'b1; end
      OP_RUN: begin m_left = LW'(len_q); m_tms = 1'b1; end
      OP_SHO: begin
        m_word = data_q;
        m_left = LW'(len_q[SHW-1:0]) + LW'(1);
        m_tdi  = 1'b1;
        m_smp  = 1'b1;
      end
      OP_SHI: begin
        m_left = LW'(len_q[SHW-1:0]) + LW'(1);
        m_smp  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_RST:        st_nxt = ST_RST;
      OP_IR, OP_DR:  st_nxt = ST_DAT;
      OP_RUN:        st_nxt = ST_RUN;
      OP_CMT:        st_nxt = (port_state == ST_DAT) ? ST_CMT : port_state;
      default:       st_nxt = port_state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      pcnt       <= '0;
      word       <= '0;
      cap        <= '0;
      data_q     <= '0;
      left       <= '0;
      idx        <= '0;
      op_q       <= OP_REL;
      len_q      <= '0;
      drv_tms    <= 1'b0;
      drv_tdi    <= 1'b0;
      smp        <= 1'b0;
      pend       <= 1'b0;
      port_state <= ST_RST;
      tck        <= 1'b0;
      tms        <= 1'b1;
      tdi        <= 1'b1;
      trst_n     <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          len_q  <= cmd_len;
          data_q <= cmd_data;
          ph     <= PH_START;
        end
        PH_START: begin
          cap <= '0;
          idx <= '0;
          if (op_q == OP_RST) begin
            trst_n <= 1'b0;
            tck    <= 1'b0;
            tdi    <= 1'b1;
          end
          if (op_q == OP_REL) trst_n <= 1'b1;
          if (need_pc) begin
            word    <= DW'(2'b11);
            left    <= LW'(2);
            drv_tms <= 1'b1;
            drv_tdi <= 1'b0;
            smp     <= 1'b0;
            pend    <= (op_q != OP_CMT);
            ph      <= PH_SET;
          end else if (m_left == '0) begin
            ph <= PH_DONE;
          end else begin
            word    <= m_word;
            left    <= m_left;
            drv_tms <= m_tms;
            drv_tdi <= m_tdi;
            smp     <= m_smp;
            pend    <= 1'b0;
            ph      <= PH_SET;
          end
        end
        PH_SET: begin
          if (drv_tms) begin
            tms  <= word[0];
            word <= word >> 1;
          end
          pcnt <= '0;
          ph   <= PH_PRE;
        end
        PH_PRE: if (wait_end) begin
          pcnt <= '0;
          tck  <= 1'b1;
          ph   <= PH_HIGH;
        end else pcnt <= pcnt + CW'(1);
        PH_HIGH: if (wait_end) begin
          pcnt <= '0;
          tck  <= 1'b0;
          ph   <= PH_LOW;
        end else pcnt <= pcnt + CW'(1);
        PH_LOW: if (wait_end) begin
          pcnt <= '0;
          if (drv_tdi) begin
            tdi  <= word[0];
            word <= word >> 1;
          end
          if (smp) cap[idx] <= tdo;
          idx  <= idx + SHW'(1);
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            if (pend && m_left != '0) begin
              word    <= m_word;
              left    <= m_left;
              drv_tms <= m_tms;
              drv_tdi <= m_tdi;
              smp     <= m_smp;
              pend    <= 1'b0;
              ph      <= PH_SET;
            end else begin
              pend <= 1'b0;
              ph   <= PH_DONE;
            end
          end else ph <= PH_SET;
        end else pcnt <= pcnt + CW'(1);
        PH_DONE: begin
          port_state <= st_nxt;
          ph         <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jtag_seq_chk.sv
module jtag_seq_chk #(
  parameter int HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       rsp_done,
  input logic [1:0] port_state,
  input logic       tck,
  input logic       tms,
  input logic       tdi,
  input logic       trst_n
);
  int hi;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi <= 0;
    else        hi <= tck ? hi + 1 : 0;

  assert_tck_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tck) |-> hi == HALF);

  assert_lines_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));

  assert_trst_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trst_n) |-> $past(cmd_op == 3'd0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tck);

  assert_state_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_state) |-> $past(rsp_done));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind jtag_seq jtag_seq_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_done(rsp_done), .port_state(port_state),
  .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n)
);

// File: tb/jtag_seq_tb.sv
`timescale 1ns/1ps
module jtag_seq_tb;
  localparam int HALF = 2;
  localparam int RUN_W = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [RUN_W-1:0] cmd_len = '0;
  logic [DW-1:0] cmd_data = '0;
  logic tdo = 1'b0;
  logic cmd_ready, rsp_done, tck, tms, tdi, trst_n;
  logic [DW-1:0] rsp_data;
  logic [1:0] port_state;

  always #2 clk = ~clk;

  jtag_seq #(.HALF(HALF), .RUN_W(RUN_W), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .port_state(port_state),
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo)
  );

  int nchk = 0, nerr = 0;
  int npulse, k, ndone, wmin, wmax;
  logic [63:0] tms_log, tdi_log;
  logic [DW-1:0] pat;
  logic [DW-1:0] resp;
  realtime t_rise;
  bit finished = 0;

  always @(posedge tck) begin
    if (npulse < 64) begin
      tms_log[npulse] = tms;
      tdi_log[npulse] = tdi;
    end
    npulse++;
    t_rise = $realtime;
  end

  always @(negedge tck) begin
    int w;
    w = int'(($realtime - t_rise) / 4.0);
    if (w < wmin) wmin = w;
    if (w > wmax) wmax = w;
    tdo = pat[k % DW];
    k++;
  end

  always @(negedge clk) if (rsp_done) ndone++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] first_bits(logic [63:0] v, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n && i < 32; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic run_cmd(logic [2:0] op, logic [RUN_W-1:0] len, logic [DW-1:0] d, logic [DW-1:0] p);
    npulse = 0; k = 0; ndone = 0; wmin = 1000; wmax = 0;
    tms_log = '0; tdi_log = '0; pat = p;
    @(negedge clk);
    cmd_op = op; cmd_len = len; cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 busy", {31'd0, cmd_ready}, 32'd0);
    while (!rsp_done) @(negedge clk);
    resp = rsp_data;
    @(negedge clk);
    chk("R10 done count", ndone, 1);
    chk("R10 ready back", {31'd0, cmd_ready}, 32'd1);
    if (npulse > 0) begin
      chk("R9 high width min", wmin, HALF);
      chk("R9 high width max", wmax, HALF);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 tck", {31'd0, tck}, 0);
    chk("R1 tms", {31'd0, tms}, 1);
    chk("R1 tdi", {31'd0, tdi}, 1);
    chk("R1 trst_n", {31'd0, trst_n}, 0);
    chk("R1 ready", {31'd0, cmd_ready}, 1);
    chk("R1 state", {30'd0, port_state}, 0);
  endtask

  task automatic t_port_reset();
    run_cmd(3'd0, '0, '0, '0);
    chk("R2 pulses", npulse, 7);
    chk("R2 tms word", first_bits(tms_log, 7), 32'h1F);
    chk("R2 trst_n", {31'd0, trst_n}, 0);
    chk("R2 tdi", {31'd0, tdi}, 1);
    chk("R2 state", {30'd0, port_state}, 0);
  endtask

  task automatic t_release();
    run_cmd(3'd1, '0, '0, '0);
    chk("R3 trst_n", {31'd0, trst_n}, 1);
    chk("R3 pulses", npulse, 0);
    chk("R3 state", {30'd0, port_state}, 0);
  endtask

  task automatic t_commit_idle();
    run_cmd(3'd4, '0, '0, '0);
    chk("R4 no pulse", npulse, 0);
    chk("R4 state kept", {30'd0, port_state}, 0);
  endtask

  task automatic t_run();
    run_cmd(3'd5, 8'd10, '0, '0);
    chk("R5 pulses", npulse, 10);
    chk("R5 tms low", first_bits(tms_log, 10), 0);
    chk("R5 state", {30'd0, port_state}, 2);
  endtask

  task automatic t_dr_shift_out();
    logic prior;
    run_cmd(3'd3, '0, '0, '0);
    chk("R6 dr pulses", npulse, 2);
    chk("R6 dr tms", first_bits(tms_log, 2), 32'h1);
    chk("R6 dr state", {30'd0, port_state}, 3);
    prior = tdi;
    run_cmd(3'd6, 8'd7, 32'hA5, 32'h3C);
    chk("R7 pulses", npulse, 8);
    chk("R7 capture", resp, 32'h3C);
    chk("R7 tdi lag", first_bits(tdi_log, 8), ((32'hA5 << 1) | {31'd0, prior}) & 32'hFF);
    chk("R7 tdi final", {31'd0, tdi}, 1);
    chk("R8 state kept", {30'd0, port_state}, 3);
  endtask

  task automatic t_commit_data();
    run_cmd(3'd4, '0, '0, '0);
    chk("R4 pulses", npulse, 2);
    chk("R4 tms", first_bits(tms_log, 2), 32'h3);
    chk("R4 state", {30'd0, port_state}, 1);
  endtask

  task automatic t_ir_run();
    run_cmd(3'd2, '0, '0, '0);
    chk("R6 ir pulses", npulse, 3);
    chk("R6 ir tms", first_bits(tms_log, 3), 32'h3);
    chk("R6 ir state", {30'd0, port_state}, 3);
    run_cmd(3'd5, 8'd3, '0, '0);
    chk("R5 precommit pulses", npulse, 5);
    chk("R5 precommit tms", first_bits(tms_log, 5), 32'h3);
    chk("R5 state", {30'd0, port_state}, 2);
  endtask

  task automatic t_shift_in();
    logic prior;
    run_cmd(3'd3, '0, '0, '0);
    prior = tdi;
    run_cmd(3'd7, 8'd31, 32'h0, 32'hDEADBEEF);
    chk("R8 pulses", npulse, 32);
    chk("R8 capture", resp, 32'hDEADBEEF);
    chk("R8 tdi held", first_bits(tdi_log, 32), prior ? 32'hFFFFFFFF : 32'h0);
    chk("R8 tdi after", {31'd0, tdi}, {31'd0, prior});
  endtask

  task automatic t_one_bit();
    run_cmd(3'd7, 8'd0, '0, 32'h1);
    chk("R7 one pulse", npulse, 1);
    chk("R7 one bit", resp, 32'h1);
  endtask

  task automatic t_ir_from_data();
    run_cmd(3'd2, '0, '0, '0);
    chk("R6 reopen pulses", npulse, 5);
    chk("R6 reopen tms", first_bits(tms_log, 5), 32'hF);
    chk("R6 reopen state", {30'd0, port_state}, 3);
  endtask

  task automatic t_reset_from_data();
    run_cmd(3'd0, '0, '0, '0);
    chk("R2 again pulses", npulse, 7);
    chk("R2 again tms", first_bits(tms_log, 7), 32'h1F);
    chk("R2 again trst_n", {31'd0, trst_n}, 0);
    chk("R2 again state", {30'd0, port_state}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_port_reset();
    t_release();
    t_commit_idle();
    t_run();
    t_dr_shift_out();
    t_commit_data();
    t_ir_run();
    t_shift_in();
    t_one_bit();
    t_ir_from_data();
    t_reset_from_data();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule